// File: doc/BRIEF.md
# On-Screen Display Serial Command Receiver

This block is the command front end of a character overlay engine. A host writes to it over a three-wire link: an active-low select, a data line and a bit clock. All three lines are sampled with the system clock, so the link may run at any rate well below it. The block gathers the bits into bytes and sorts each byte into a command byte or a data byte. It then either moves the display-memory write pointer, sends a character to the display memory, or updates one of six configuration slots that the video side reads.

A command byte selects one of eight commands, and that selection stays in force for any number of following data bytes. The character-write command is different: once it arrives, every later byte is taken as a character code, whatever its top bit, until the select line is released. Releasing the select line always returns the receiver to pointer-setting mode. Command 4 can also ask for a soft reset of every register and can request an erase of the display memory. The erase itself is carried out by the memory side.

Top module: `osd_cmd_rx`

## Requirements
- R1: While rst_n is low, and right after it rises, addr_row, addr_col, char_attr, cfg_head and cfg_data are zero, and char_we, soft_rst and erase_req are low.
- R2: Bits are taken most significant first, on rising edges of sclk while sel_n is low. A byte that is only partly received when sel_n rises is discarded.
- R3: A byte with bit 7 = 1 is a command byte, and its bits 6:4 give the command number. A byte with bit 7 = 0 is a data byte. The command number stays in force until the next command byte, so every data byte that follows goes to the same command, and the last one wins.
- R4: Command 0 loads addr_row from command-byte bits 3:0, but only if the value is below ROWS. Its data bytes load addr_col from bits 4:0, but only if the value is below COLS. An out-of-range value leaves the pointer unchanged.
- R5: Command 1 loads char_attr from command-byte bits 1:0 (bit 1 = highlight/flash, bit 0 = reverse video) and locks the receiver. Every later byte, including one with bit 7 = 1, gives a one-cycle char_we pulse with char_code = byte bits 6:0, char_attr, and the pointer at char_row/char_col.
- R6: After each character write the pointer advances by one column. From column COLS-1 it goes to column 0 of the next row, and from row ROWS-1, column COLS-1 it goes to row 0, column 0.
- R7: A rising edge on sel_n clears the lock and selects command 0. The pointer is kept.
- R8: Command k (2 to 7) stores its command-byte bits 3:0 in cfg_head[4(k-2)+3 : 4(k-2)] and its data-byte bits 6:0 in cfg_data[7(k-2)+6 : 7(k-2)].
- R9: A command-4 byte with bit 3 = 1 gives a one-cycle soft_rst pulse. It clears cfg_head, cfg_data, the pointer and char_attr, and selects command 0.
- R10: A command-4 byte with bit 2 = 1 gives a one-cycle erase_req pulse, and bit 2 of that command byte is kept in cfg_head[10].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Link select, active low |
| sclk | input | 1 | Link bit clock |
| sdata | input | 1 | Link serial data |
| char_we | output | 1 | Character write strobe, one cycle |
| char_row | output | ROW_W | Row of the character being written |
| char_col | output | COL_W | Column of the character being written |
| char_code | output | 7 | Character code being written |
| char_attr | output | 2 | Current attributes (highlight/flash, reverse) |
| addr_row | output | ROW_W | Current write-pointer row |
| addr_col | output | COL_W | Current write-pointer column |
| cfg_head | output | 24 | Command-byte fields of commands 2 to 7 |
| cfg_data | output | 42 | Data-byte fields of commands 2 to 7 |
| soft_rst | output | 1 | Soft reset pulse |
| erase_req | output | 1 | Display-memory erase request pulse |

## Verification
The bench builds the block with its default geometry of 12 rows by 24 columns and a two-stage input synchronizer. It writes from row 11, column 22, so that three writes carry the pointer through both the column wrap and the row wrap. The 4-bit row field and the 5-bit column field can both hold values just past the grid (12 and 24), so the ignore rule on out-of-range pointer values can be checked at the ports. With two synchronizer stages, each received byte takes effect a few system cycles after its last bit clock. The bench waits out that delay before it samples.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
  localparam int CMD_W     = 3;
  localparam int HEAD_W    = 4;
  localparam int DATA_W    = 7;
  localparam int FIRST_CFG = 2;
  localparam int NUM_CFG   = 8 - FIRST_CFG;
  localparam int SLOT_W    = $clog2(NUM_CFG);

  typedef enum logic [CMD_W-1:0] {
    CMD_ADDR = 3'd0,
    CMD_CHAR = 3'd1,
    CMD_VPOS = 3'd2,
    CMD_HPOS = 3'd3,
    CMD_CTL1 = 3'd4,
    CMD_CTL2 = 3'd5,
    CMD_CTL3 = 3'd6,
    CMD_CTL4 = 3'd7
  } osd_cmd_e;

  // slot index of a configuration command
  function automatic logic [SLOT_W-1:0] cfg_slot(input logic [CMD_W-1:0] c);
    return SLOT_W'(c - CMD_W'(FIRST_CFG));
  endfunction
endpackage

// File: rtl/osd_ser_shift.sv
module osd_ser_shift #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       sclk,
  input  logic       sdata,
  output logic       byte_vld,
  output logic [7:0] byte_q,
  output logic       sel_rise
);
  logic [SYNC-1:0] s_sel, s_clk, s_dat;
  logic            sel_d, sclk_d;
  logic [6:0]      sh;
  logic [2:0]      cnt;
  logic            sel_act, clk_rise, dbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sel  <= '1;
      s_clk  <= '1;
      s_dat  <= '0;
      sel_d  <= 1'b1;
      sclk_d <= 1'b1;
    end else begin
      s_sel  <= {s_sel[SYNC-2:0], sel_n};
      s_clk  <= {s_clk[SYNC-2:0], sclk};
      s_dat  <= {s_dat[SYNC-2:0], sdata};
      sel_d  <= s_sel[SYNC-1];
      sclk_d <= s_clk[SYNC-1];
    end
  end

  assign sel_act  = ~s_sel[SYNC-1];
  assign clk_rise = s_clk[SYNC-1] & ~sclk_d;
  assign sel_rise = s_sel[SYNC-1] & ~sel_d;
  assign dbit     = s_dat[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!sel_act) begin
        cnt <= '0;
      end else if (clk_rise) begin
        sh  <= {sh[5:0], dbit};
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_q   <= {sh, dbit};
        end
      end
    end
  end
endmodule

// File: rtl/osd_cmd_fsm.sv
module osd_cmd_fsm
  import osd_cmd_pkg::*;
#(
  parameter int ROWS  = 12,
  parameter int COLS  = 24,
  parameter int ROW_W = $clog2(ROWS),
  parameter int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_i,
  input  logic              sel_rise,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              lock_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [1:0]        attr_o,
  output logic              char_we_o,
  output logic [ROW_W-1:0]  char_row_o,
  output logic [COL_W-1:0]  char_col_o,
  output logic [DATA_W-1:0] char_code_o,
  output logic              head_we_o,
  output logic [SLOT_W-1:0] head_slot_o,
  output logic              data_we_o,
  output logic [SLOT_W-1:0] data_slot_o,
  output logic              clear_o,
  output logic              soft_rst_o,
  output logic              erase_o
);
  osd_cmd_e         cmd_q;
  logic [CMD_W-1:0] new_cmd;
  logic             is_cmd, ev_char, ev_soft, ev_erase;
  logic             ev_row, ev_col, ev_attr;
  logic [ROW_W+COL_W-1:0] nxt;

  function automatic logic [ROW_W+COL_W-1:0] step_addr(
    input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    logic [ROW_W-1:0] nr;
    logic [COL_W-1:0] nc;
    if (int'(c) == COLS - 1) begin
      nc = '0;
      nr = (int'(r) == ROWS - 1) ? '0 : r + 1'b1;
    end else begin
      nc = c + 1'b1;
      nr = r;
    end
    return {nr, nc};
  endfunction

  assign new_cmd  = byte_i[6:4];
  assign is_cmd   = byte_vld && byte_i[7] && !lock_o;
  assign ev_char  = byte_vld && lock_o;
  assign ev_soft  = is_cmd && (new_cmd == CMD_CTL1) && byte_i[3];
  assign ev_erase = is_cmd && (new_cmd == CMD_CTL1) && byte_i[2];
  assign ev_row   = is_cmd && (new_cmd == CMD_ADDR) && (int'(byte_i[3:0]) < ROWS);
  assign ev_attr  = is_cmd && (new_cmd == CMD_CHAR);
  assign ev_col   = byte_vld && !byte_i[7] && !lock_o && (cmd_q == CMD_ADDR)
                    && (int'(byte_i[4:0]) < COLS);

  assign head_we_o   = is_cmd && (int'(new_cmd) >= FIRST_CFG) && !ev_soft;
  assign head_slot_o = cfg_slot(new_cmd);
  assign data_we_o   = byte_vld && !byte_i[7] && !lock_o && (int'(cmd_q) >= FIRST_CFG);
  assign data_slot_o = cfg_slot(cmd_q);
  assign clear_o     = ev_soft;
  assign nxt         = step_addr(row_o, col_o);
  assign cmd_o       = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q       <= CMD_ADDR;
      lock_o      <= 1'b0;
      row_o       <= '0;
      col_o       <= '0;
      attr_o      <= '0;
      char_we_o   <= 1'b0;
      char_row_o  <= '0;
      char_col_o  <= '0;
      char_code_o <= '0;
      soft_rst_o  <= 1'b0;
      erase_o     <= 1'b0;
    end else begin
      char_we_o  <= 1'b0;
      soft_rst_o <= ev_soft;
      erase_o    <= ev_erase;
      if (sel_rise) begin
        cmd_q  <= CMD_ADDR;
        lock_o <= 1'b0;
      end else if (ev_soft) begin
        cmd_q  <= CMD_ADDR;
        lock_o <= 1'b0;
        row_o  <= '0;
        col_o  <= '0;
        attr_o <= '0;
      end else if (ev_char) begin
        char_we_o   <= 1'b1;
        char_code_o <= byte_i[DATA_W-1:0];
        char_row_o  <= row_o;
        char_col_o  <= col_o;
        {row_o, col_o} <= nxt;
      end else if (is_cmd) begin
        cmd_q <= osd_cmd_e'(new_cmd);
        if (ev_row)  row_o <= ROW_W'(byte_i[3:0]);
        if (ev_attr) begin
          attr_o <= byte_i[1:0];
          lock_o <= 1'b1;
        end
      end else if (ev_col) begin
        col_o <= COL_W'(byte_i[4:0]);
      end
    end
  end
endmodule

// File: rtl/osd_cfg_regs.sv
module osd_cfg_regs
  import osd_cmd_pkg::*;
#(
  parameter int NUM = NUM_CFG,
  parameter int HW  = HEAD_W,
  parameter int DW  = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              head_we,
  input  logic [SLOT_W-1:0] head_slot,
  input  logic [HW-1:0]     head_val,
  input  logic              data_we,
  input  logic [SLOT_W-1:0] data_slot,
  input  logic [DW-1:0]     data_val,
  output logic [NUM*HW-1:0] head_flat,
  output logic [NUM*DW-1:0] data_flat
);
  for (genvar g = 0; g < NUM; g++) begin : g_slot
    logic [HW-1:0] head_q;
    logic [DW-1:0] data_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        head_q <= '0;
        data_q <= '0;
      end else if (clear) begin
        head_q <= '0;
        data_q <= '0;
      end else begin
        if (head_we && head_slot == SLOT_W'(g)) head_q <= head_val;
        if (data_we && data_slot == SLOT_W'(g)) data_q <= data_val;
      end
    end
    assign head_flat[g*HW +: HW] = head_q;
    assign data_flat[g*DW +: DW] = data_q;
  end
endmodule

// File: rtl/osd_cmd_rx.sv
module osd_cmd_rx
  import osd_cmd_pkg::*;
#(
  parameter int ROWS  = 12,
  parameter int COLS  = 24,
  parameter int SYNC  = 2,
  parameter int ROW_W = $clog2(ROWS),
  parameter int COL_W = $clog2(COLS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_n,
  input  logic                      sclk,
  input  logic                      sdata,
  output logic                      char_we,
  output logic [ROW_W-1:0]          char_row,
  output logic [COL_W-1:0]          char_col,
  output logic [DATA_W-1:0]         char_code,
  output logic [1:0]                char_attr,
  output logic [ROW_W-1:0]          addr_row,
  output logic [COL_W-1:0]          addr_col,
  output logic [NUM_CFG*HEAD_W-1:0] cfg_head,
  output logic [NUM_CFG*DATA_W-1:0] cfg_data,
  output logic                      soft_rst,
  output logic                      erase_req
);
  logic              byte_vld_w, sel_rise_w, lock_w;
  logic [7:0]        byte_w;
  logic [CMD_W-1:0]  cmd_w;
  logic              head_we_w, data_we_w, clear_w;
  logic [SLOT_W-1:0] head_slot_w, data_slot_w;

  osd_ser_shift #(.SYNC(SYNC)) shift_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata(sdata),
    .byte_vld(byte_vld_w), .byte_q(byte_w), .sel_rise(sel_rise_w)
  );

  osd_cmd_fsm #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld_w), .byte_i(byte_w),
    .sel_rise(sel_rise_w), .cmd_o(cmd_w), .lock_o(lock_w),
    .row_o(addr_row), .col_o(addr_col), .attr_o(char_attr),
    .char_we_o(char_we), .char_row_o(char_row), .char_col_o(char_col),
    .char_code_o(char_code), .head_we_o(head_we_w), .head_slot_o(head_slot_w),
    .data_we_o(data_we_w), .data_slot_o(data_slot_w), .clear_o(clear_w),
    .soft_rst_o(soft_rst), .erase_o(erase_req)
  );

  osd_cfg_regs regs_i (
    .clk(clk), .rst_n(rst_n), .clear(clear_w),
    .head_we(head_we_w), .head_slot(head_slot_w), .head_val(byte_w[HEAD_W-1:0]),
    .data_we(data_we_w), .data_slot(data_slot_w), .data_val(byte_w[DATA_W-1:0]),
    .head_flat(cfg_head), .data_flat(cfg_data)
  );
endmodule

// File: rtl/osd_cmd_rx_chk.sv
module osd_cmd_rx_chk
  import osd_cmd_pkg::*;
#(
  parameter int ROWS  = 12,
  parameter int COLS  = 24,
  parameter int ROW_W = $clog2(ROWS),
  parameter int COL_W = $clog2(COLS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      char_we,
  input logic [ROW_W-1:0]          char_row,
  input logic [COL_W-1:0]          char_col,
  input logic [ROW_W-1:0]          addr_row,
  input logic [COL_W-1:0]          addr_col,
  input logic                      lock_w,
  input logic [CMD_W-1:0]          cmd_w,
  input logic                      sel_rise_w,
  input logic                      soft_rst,
  input logic                      erase_req,
  input logic [NUM_CFG*HEAD_W-1:0] cfg_head,
  input logic [NUM_CFG*DATA_W-1:0] cfg_data
);
  // R4
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(addr_row) < ROWS);
  // R4
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(addr_col) < COLS);
  // R6
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_we && int'(char_col) < COLS - 1) |->
      (int'(addr_col) == int'(char_col) + 1 && addr_row == char_row));
  // R6
  grid_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_we && int'(char_col) == COLS - 1 && int'(char_row) == ROWS - 1) |->
      (addr_row == '0 && addr_col == '0));
  // R7
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise_w |=> (!lock_w && cmd_w == '0));
  // R9
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (cfg_head == '0 && cfg_data == '0 && addr_row == '0 && addr_col == '0));
  // R10
  erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);
endmodule

bind osd_cmd_rx osd_cmd_rx_chk #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .char_we(char_we), .char_row(char_row),
  .char_col(char_col), .addr_row(addr_row), .addr_col(addr_col),
  .lock_w(lock_w), .cmd_w(cmd_w), .sel_rise_w(sel_rise_w),
  .soft_rst(soft_rst), .erase_req(erase_req),
  .cfg_head(cfg_head), .cfg_data(cfg_data)
);

// File: tb/osd_cmd_rx_tb.sv
`timescale 1ns/1ps
module osd_cmd_rx_tb_top;
  localparam int ROWS = 12;
  localparam int COLS = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b1, sdata = 1'b0;
  logic char_we, soft_rst, erase_req;
  logic [3:0] char_row, addr_row;
  logic [4:0] char_col, addr_col;
  logic [6:0] char_code;
  logic [1:0] char_attr;
  logic [23:0] cfg_head;
  logic [41:0] cfg_data;

  always #2 clk = ~clk;

  osd_cmd_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata(sdata),
    .char_we(char_we), .char_row(char_row), .char_col(char_col),
    .char_code(char_code), .char_attr(char_attr), .addr_row(addr_row),
    .addr_col(addr_col), .cfg_head(cfg_head), .cfg_data(cfg_data),
    .soft_rst(soft_rst), .erase_req(erase_req)
  );

  int n_tests = 0, n_fail = 0;
  int n_wr = 0, n_srst = 0, n_er = 0;
  logic [6:0] log_code [16];
  logic [3:0] log_row  [16];
  logic [4:0] log_col  [16];
  logic [1:0] log_attr [16];

  always @(negedge clk) begin
    if (char_we && n_wr < 16) begin
      log_code[n_wr] = char_code;
      log_row[n_wr]  = char_row;
      log_col[n_wr]  = char_col;
      log_attr[n_wr] = char_attr;
    end
    if (char_we)   n_wr++;
    if (soft_rst)  n_srst++;
    if (erase_req) n_er++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sclk = 1'b0; sdata = b[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
    repeat (4) @(negedge clk);
  endtask

  task automatic open_frame();
    sel_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic close_frame();
    repeat (6) @(negedge clk);
    sel_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // command byte, data byte per configuration command 2..7
  localparam logic [15:0] CFG_VEC [6] = '{
    16'hA5_2A, 16'hB6_11, 16'hC1_45, 16'hDE_3C, 16'hE9_0F, 16'hF1_3F
  };

  bit done = 1'b0;

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int lin, w0, s0, e0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(addr_row == 0 && addr_col == 0 && char_attr == 0, "R1 addr/attr", {addr_row, addr_col, char_attr}, 0);
    check(cfg_head == 0 && cfg_data == 0, "R1 cfg", cfg_head, 0);
    check(!char_we && !soft_rst && !erase_req, "R1 pulses", {char_we, soft_rst, erase_req}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(addr_row == 0 && addr_col == 0 && cfg_head == 0, "R1 after release", addr_col, 0);

    // R8 table walk, all in one frame
    open_frame();
    for (int k = 0; k < 6; k++) begin
      send_byte(CFG_VEC[k][15:8]);
      send_byte(CFG_VEC[k][7:0]);
    end
    close_frame();
    for (int k = 0; k < 6; k++) begin
      check(cfg_head[4*k +: 4] == CFG_VEC[k][11:8], "R8 head", cfg_head[4*k +: 4], CFG_VEC[k][11:8]);
      check(cfg_data[7*k +: 7] == CFG_VEC[k][6:0], "R8 data", cfg_data[7*k +: 7], CFG_VEC[k][6:0]);
    end

    // R3 persistence: one command byte, two data bytes
    open_frame();
    send_byte(8'hA3); send_byte(8'h11); send_byte(8'h22);
    close_frame();
    check(cfg_head[3:0] == 4'h3, "R3 head", cfg_head[3:0], 3);
    check(cfg_data[6:0] == 7'h22, "R3 last data wins", cfg_data[6:0], 7'h22);
    check(cfg_data[13:7] == 7'h11, "R3 other slot kept", cfg_data[13:7], 7'h11);

    // R4 pointer set, out-of-range ignored; R2 MSB first (0x05 LSB-first would be a command)
    open_frame();
    send_byte(8'h82); send_byte(8'h05);
    check(addr_row == 2 && addr_col == 5, "R2 R4 set", {addr_row, addr_col}, {4'd2, 5'd5});
    send_byte(8'h8C); send_byte(8'h18);
    close_frame();
    check(addr_row == 2 && addr_col == 5, "R4 ignore 12/24", {addr_row, addr_col}, {4'd2, 5'd5});

    // R5 R6 lock and wrap
    w0 = n_wr;
    open_frame();
    send_byte(8'h8B); send_byte(8'h16); send_byte(8'h93);
    send_byte(8'h41); send_byte(8'hC2); send_byte(8'h43);
    check(n_wr - w0 == 3, "R5 write count", n_wr - w0, 3);
    lin = 11 * COLS + 22;
    for (int i = 0; i < 3; i++) begin
      check(log_row[w0+i] == 4'(lin / COLS) && log_col[w0+i] == 5'(lin % COLS),
            "R6 write address", {log_row[w0+i], log_col[w0+i]}, {4'(lin / COLS), 5'(lin % COLS)});
      check(log_code[w0+i] == 7'(8'h41 + i) && log_attr[w0+i] == 2'b11, "R5 code/attr",
            {log_attr[w0+i], log_code[w0+i]}, {2'b11, 7'(8'h41 + i)});
      lin = (lin + 1) % (ROWS * COLS);
    end
    check(addr_row == 0 && addr_col == 1, "R6 wrap to origin", {addr_row, addr_col}, {4'd0, 5'd1});
    close_frame();

    // R7 release restores command 0, pointer kept
    w0 = n_wr;
    open_frame();
    send_byte(8'h07);
    close_frame();
    check(n_wr == w0 && addr_col == 7 && addr_row == 0, "R7 unlock", {n_wr - w0, addr_col}, 7);

    // R2 partial byte discarded
    open_frame();
    send_bits(8'hFF, 3);
    close_frame();
    open_frame();
    send_byte(8'h0C);
    close_frame();
    check(addr_col == 12, "R2 partial dropped", addr_col, 12);

    // R10 erase request
    e0 = n_er;
    open_frame();
    send_byte(8'hC4);
    close_frame();
    check(n_er - e0 == 1 && cfg_head[11:8] == 4'h4, "R10 erase", {n_er - e0, cfg_head[11:8]}, {1, 4'h4});

    // R9 soft reset, then data goes to command 0
    s0 = n_srst;
    open_frame();
    send_byte(8'h83); send_byte(8'h04); send_byte(8'h91); send_byte(8'h90);
    close_frame();
    open_frame();
    send_byte(8'hC8);
    check(n_srst - s0 == 1, "R9 pulse", n_srst - s0, 1);
    check(cfg_head == 0 && cfg_data == 0 && char_attr == 0, "R9 cleared", cfg_head, 0);
    send_byte(8'h09);
    close_frame();
    check(addr_row == 0 && addr_col == 9, "R9 back to command 0", {addr_row, addr_col}, 9);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule